// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block receives configuration writes from a host over a three-wire serial link made of an active-low select, a serial clock and a data line. It holds the settings for two channels, X and Y. Each channel has a control byte, an input time-slot byte and an output time-slot byte. Many devices can share the same three wires. The first byte of every transfer carries a 6-bit device address, a channel selector and one reserved bit. The block compares the address with its own strap inputs. If the address matches, the bytes that follow are written into the selected channel. A transfer of two bytes updates only the control byte. A transfer of four bytes also writes the input slot and then the output slot.

The select, clock and data lines are brought into the system clock domain through synchronisers. The serial clock is then edge-detected there. The control byte includes an algorithm-reset bit, which the block clears by itself when the processing engine reports that its reset is done. While a matched write is in progress, a flag tells the data interfaces to place their outputs in high impedance. A low-power flag follows the idle bits of the two channels. When the mode strap is low, the port ignores all traffic and every time-slot output reads zero. The link is write-only and has no back-pressure: the host sets the pace, and the block accepts each bit on the clock edge at which the bit arrives.

Top module: `cfg_port_top`

## Requirements
- R1: After reset, both control outputs read 0x20 (only the idle bit, bit 5, is set), all four time-slot outputs read 0, `data_hiz_o` is 0 and `low_power_o` is 1.
- R2: Data bits are taken on rising edges of the serial clock, least significant bit first, and only while `cfg_csn_i` is low. Clock edges seen while the select is high shift nothing.
- R3: In the first byte of a transfer, bits 5..0 must equal `dev_addr_i` and bit 7 must be 0. Bit 6 picks the channel: 1 selects X and 0 selects Y. A first byte with bit 7 set is treated as a mismatch.
- R4: After a mismatching first byte, every later byte of that transfer leaves all registers unchanged.
- R5: A matched transfer of two bytes loads the second byte into the selected channel's control register. The time-slot registers of both channels and the other channel's control register keep their values.
- R6: A matched transfer of four bytes loads control, input slot and output slot, in that byte order. Any byte after the fourth is ignored.
- R7: If the select goes high in the middle of a byte, the partial byte is discarded. Bytes that were completed before that point stay written.
- R8: Bit 4 of a control register (algorithm reset) is cleared on the cycle after the matching bit of `alg_rst_done_i` is high, where bit 1 belongs to X and bit 0 to Y. The other bits of that register are not changed.
- R9: `data_hiz_o` goes high once a matching first byte has been received, and falls once the select goes high. It stays low for transfers that do not match.
- R10: While `sw_mode_i` is low, transfers change no register and all time-slot outputs read 0. When the strap goes high again, the stored values appear on the outputs.
- R11: `low_power_o` is high exactly when bit 5 (idle) is set in both control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_mode_i | input | 1 | Mode strap: 1 enables the serial port, 0 selects hardware mode |
| dev_addr_i | input | 6 | Device address straps |
| cfg_csn_i | input | 1 | Serial select, active low |
| cfg_sclk_i | input | 1 | Serial clock |
| cfg_sdi_i | input | 1 | Serial data, LSB first |
| alg_rst_done_i | input | 2 | Algorithm reset complete, bit 1 = X, bit 0 = Y |
| ctrl_x_o | output | 8 | Channel X control register |
| ctrl_y_o | output | 8 | Channel Y control register |
| slot_in_x_o | output | 8 | Channel X input time slot |
| slot_out_x_o | output | 8 | Channel X output time slot |
| slot_in_y_o | output | 8 | Channel Y input time slot |
| slot_out_y_o | output | 8 | Channel Y output time slot |
| data_hiz_o | output | 1 | Data outputs to be held in high impedance |
| low_power_o | output | 1 | Both channels idle |

## Verification
A register write is visible about four system clocks after the rising serial clock edge that completes its byte. That delay is two synchroniser stages, the edge detector, the byte-valid register and the register bank. The bench holds each serial clock level for four system clocks. After the select rises, its monitor waits eight more cycles before it compares a snapshot from the scoreboard. `data_hiz_o` is sampled four cycles after the header byte's last bit, while the select is still low, and sampled again eight cycles after the select rises. A completion pulse for the algorithm-reset bit is checked two cycles after it ends.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 6;
  localparam int NCH        = 2;
  localparam int NBYTES     = 4;
  localparam int CR_IDLE    = 5;
  localparam int CR_ALRST   = 4;
  localparam int HDR_CH     = 6;
  localparam int HDR_RSV    = 7;
  localparam logic [BYTE_W-1:0] CR_RST_VAL = 8'h20;

  typedef enum logic [1:0] {
    IDX_HDR  = 2'd0,
    IDX_CTRL = 2'd1,
    IDX_TSI  = 2'd2,
    IDX_TSO  = 2'd3
  } byte_idx_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic cs_act_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sclk_q, csn_q, sdi_q;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      csn_q  <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q[0] <= sclk_i;
      csn_q[0]  <= csn_i;
      sdi_q[0]  <= sdi_i;
      sclk_d    <= sclk_q[STAGES-1];
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sclk_q[s] <= 1'b0;
        csn_q[s]  <= 1'b1;
        sdi_q[s]  <= 1'b0;
      end else begin
        sclk_q[s] <= sclk_q[s-1];
        csn_q[s]  <= csn_q[s-1];
        sdi_q[s]  <= sdi_q[s-1];
      end
    end
  end

  assign sclk_rise_o = sclk_q[STAGES-1] & ~sclk_d;
  assign cs_act_o    = ~csn_q[STAGES-1];
  assign sdi_o       = sdi_q[STAGES-1];
endmodule

// File: rtl/cfgp_deser.sv
module cfgp_deser
  import cfgp_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output byte_idx_e         idx_o
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam int IC_W = $clog2(NB + 1);

  logic [BYTE_W-1:0] shreg;
  logic [BC_W-1:0]   bit_cnt;
  logic [IC_W-1:0]   idx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      idx_cnt    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      idx_o      <= IDX_HDR;
    end else begin
      byte_vld_o <= 1'b0;
      if (!en_i || !cs_act_i) begin
        bit_cnt <= '0;
        idx_cnt <= '0;
      end else if (sclk_rise_i) begin
        shreg   <= {sdi_i, shreg[BYTE_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BC_W'(BYTE_W - 1) && idx_cnt < IC_W'(NB)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sdi_i, shreg[BYTE_W-1:1]};
          idx_o      <= byte_idx_e'(idx_cnt[1:0]);
          idx_cnt    <= idx_cnt + 1'b1;
        end
      end
    end
  end

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act_i |=> (bit_cnt == '0 && idx_cnt == '0));
  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);
  // R10
  hw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !byte_vld_o);
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
  import cfgp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_i,
  input  logic                         cs_act_i,
  input  logic                         byte_vld_i,
  input  logic [BYTE_W-1:0]            byte_i,
  input  byte_idx_e                    idx_i,
  input  logic [ADDR_W-1:0]            dev_addr_i,
  input  logic [NCH-1:0]               alrst_done_i,
  output logic [NCH-1:0][BYTE_W-1:0]   ctrl_o,
  output logic [NCH-1:0][BYTE_W-1:0]   tsi_o,
  output logic [NCH-1:0][BYTE_W-1:0]   tso_o,
  output logic                         upd_o
);
  logic matched, sel_ch, wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matched <= 1'b0;
      sel_ch  <= 1'b0;
    end else if (!cs_act_i || !en_i) begin
      matched <= 1'b0;
    end else if (byte_vld_i && idx_i == IDX_HDR) begin
      matched <= (byte_i[ADDR_W-1:0] == dev_addr_i) && !byte_i[HDR_RSV];
      sel_ch  <= byte_i[HDR_CH];
    end
  end

  assign wr    = byte_vld_i && matched && idx_i != IDX_HDR;
  assign upd_o = matched;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c;
    assign wr_c = wr && (sel_ch == c[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_o[c] <= CR_RST_VAL;
        tsi_o[c]  <= '0;
        tso_o[c]  <= '0;
      end else begin
        if (wr_c && idx_i == IDX_CTRL)
          ctrl_o[c] <= byte_i;
        else if (alrst_done_i[c])
          ctrl_o[c][CR_ALRST] <= 1'b0;
        if (wr_c && idx_i == IDX_TSI) tsi_o[c] <= byte_i;
        if (wr_c && idx_i == IDX_TSO) tso_o[c] <= byte_i;
      end
    end

    // R8
    alrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alrst_done_i[c] && !(wr_c && idx_i == IDX_CTRL)) |=> !ctrl_o[c][CR_ALRST]);
  end

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && idx_i != IDX_HDR && !matched && alrst_done_i == '0)
      |=> ($stable(ctrl_o) && $stable(tsi_o) && $stable(tso_o)));
  // R9
  hiz_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act_i |=> !upd_o);
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_mode_i,
  input  logic [5:0]  dev_addr_i,
  input  logic        cfg_csn_i,
  input  logic        cfg_sclk_i,
  input  logic        cfg_sdi_i,
  input  logic [1:0]  alg_rst_done_i,
  output logic [7:0]  ctrl_x_o,
  output logic [7:0]  ctrl_y_o,
  output logic [7:0]  slot_in_x_o,
  output logic [7:0]  slot_out_x_o,
  output logic [7:0]  slot_in_y_o,
  output logic [7:0]  slot_out_y_o,
  output logic        data_hiz_o,
  output logic        low_power_o
);
  localparam int CH_X = 1;
  localparam int CH_Y = 0;

  logic              sclk_rise, cs_act, sdi_s, byte_vld;
  logic [BYTE_W-1:0] byte_d;
  byte_idx_e         idx;
  logic [NCH-1:0][BYTE_W-1:0] ctrl, tsi, tso;

  cfgp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(cfg_sclk_i), .csn_i(cfg_csn_i), .sdi_i(cfg_sdi_i),
    .sclk_rise_o(sclk_rise), .cs_act_o(cs_act), .sdi_o(sdi_s)
  );

  cfgp_deser #(.NB(NBYTES)) u_deser (
    .clk(clk), .rst_n(rst_n), .en_i(sw_mode_i), .cs_act_i(cs_act),
    .sclk_rise_i(sclk_rise), .sdi_i(sdi_s),
    .byte_vld_o(byte_vld), .byte_o(byte_d), .idx_o(idx)
  );

  cfgp_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .en_i(sw_mode_i), .cs_act_i(cs_act),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .idx_i(idx),
    .dev_addr_i(dev_addr_i), .alrst_done_i(alg_rst_done_i),
    .ctrl_o(ctrl), .tsi_o(tsi), .tso_o(tso), .upd_o(data_hiz_o)
  );

  assign ctrl_x_o     = ctrl[CH_X];
  assign ctrl_y_o     = ctrl[CH_Y];
  assign slot_in_x_o  = sw_mode_i ? tsi[CH_X] : '0;
  assign slot_out_x_o = sw_mode_i ? tso[CH_X] : '0;
  assign slot_in_y_o  = sw_mode_i ? tsi[CH_Y] : '0;
  assign slot_out_y_o = sw_mode_i ? tso[CH_Y] : '0;
  assign low_power_o  = ctrl[CH_X][CR_IDLE] & ctrl[CH_Y][CR_IDLE];
endmodule

// File: tb/cfg_port_top_tb_top.sv
module cfg_port_top_tb_top;
  typedef struct packed {
    logic [7:0] cx, cy, ix, ox, iy, oy;
    logic       lp;
  } snap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_mode = 1'b1;
  logic [5:0] addr = 6'h2A;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [1:0] done = 2'b00;
  logic [7:0] cx, cy, ix, ox, iy, oy;
  logic hiz, lp;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_ctrl [2];
  logic [7:0] m_tsi [2];
  logic [7:0] m_tso [2];
  snap_t exp_q[$];
  string tag_q[$];
  event  chk_ev;

  always #4 clk = ~clk;

  cfg_port_top dut_i (
    .clk(clk), .rst_n(rst_n), .sw_mode_i(sw_mode), .dev_addr_i(addr),
    .cfg_csn_i(csn), .cfg_sclk_i(sclk), .cfg_sdi_i(sdi),
    .alg_rst_done_i(done),
    .ctrl_x_o(cx), .ctrl_y_o(cy), .slot_in_x_o(ix), .slot_out_x_o(ox),
    .slot_in_y_o(iy), .slot_out_y_o(oy), .data_hiz_o(hiz), .low_power_o(lp)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic snap_t model_snap();
    snap_t s;
    s.cx = m_ctrl[1]; s.cy = m_ctrl[0];
    s.ix = sw_mode ? m_tsi[1] : 8'h00; s.ox = sw_mode ? m_tso[1] : 8'h00;
    s.iy = sw_mode ? m_tsi[0] : 8'h00; s.oy = sw_mode ? m_tso[0] : 8'h00;
    s.lp = m_ctrl[1][5] & m_ctrl[0][5];
    return s;
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
    -> chk_ev;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = b[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // nfull complete bytes, then pbits bits of a partial byte
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input int nfull, input int pbits, input string tag);
    logic [7:0] bs [6];
    logic match;
    int ch;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = 8'hFF; bs[5] = 8'hEE;
    match = (b0[5:0] == addr) && !b0[7] && sw_mode;
    ch = b0[6] ? 1 : 0;
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nfull; k++) begin
      send_bits(bs[k], 8);
      if (k == 0) begin
        repeat (4) @(negedge clk);
        check("R9 hiz during transfer", {7'd0, hiz}, {7'd0, match});
      end
      if (match && k == 1) m_ctrl[ch] = bs[k];
      if (match && k == 2) m_tsi[ch]  = bs[k];
      if (match && k == 3) m_tso[ch]  = bs[k];
    end
    if (pbits > 0) send_bits(8'hC3, pbits);
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 hiz after select high", {7'd0, hiz}, 8'h00);
    push(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(chk_ev);
      repeat (8) @(negedge clk);
      if (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " ctrl_x"}, cx, e.cx);
        check({t, " ctrl_y"}, cy, e.cy);
        check({t, " slot_in_x"}, ix, e.ix);
        check({t, " slot_out_x"}, ox, e.ox);
        check({t, " slot_in_y"}, iy, e.iy);
        check({t, " slot_out_y"}, oy, e.oy);
        check({t, " low_power"}, {7'd0, lp}, {7'd0, e.lp});
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 8'h20; m_tsi[c] = 8'h00; m_tso[c] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 hiz at reset", {7'd0, hiz}, 8'h00);
    push("R1 reset defaults");

    // R6 / R3: X channel, four bytes
    xfer({2'b01, 6'h2A}, 8'h81, 8'h05, 8'h09, 4, 0, "R6 four-byte X");
    // R5: two-byte write to Y, idle cleared -> R11 low power off
    xfer({2'b00, 6'h2A}, 8'h0D, 8'h00, 8'h00, 2, 0, "R5 two-byte Y / R11");
    // R4: wrong address
    xfer({2'b01, 6'h15}, 8'hAA, 8'h11, 8'h22, 4, 0, "R4 address mismatch");
    // R3: reserved bit set
    xfer({2'b11, 6'h2A}, 8'h55, 8'h33, 8'h44, 4, 0, "R3 reserved bit");
    // R6: six bytes, extra ignored
    xfer({2'b01, 6'h2A}, 8'h02, 8'h17, 8'h1F, 6, 0, "R6 extra bytes ignored");
    // R7: three bytes plus partial to Y
    xfer({2'b00, 6'h2A}, 8'h41, 8'h0C, 8'h77, 3, 5, "R7 partial byte dropped");

    // R2: clock edges with select high shift nothing
    sdi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    xfer({2'b01, 6'h2A}, 8'h96, 8'h00, 8'h00, 2, 0, "R2 LSB first, select gating");

    // R8: algorithm reset bit on X, then completion
    xfer({2'b01, 6'h2A}, 8'h13, 8'h00, 8'h00, 2, 0, "R8 alrst set");
    done = 2'b10;
    @(negedge clk);
    done = 2'b00;
    m_ctrl[1][4] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 ctrl_x after done", cx, m_ctrl[1]);
    check("R8 ctrl_y untouched", cy, m_ctrl[0]);

    // R11: idle in both channels
    xfer({2'b01, 6'h2A}, 8'h20, 8'h00, 8'h00, 2, 0, "R11 X idle");
    xfer({2'b00, 6'h2A}, 8'h24, 8'h00, 8'h00, 2, 0, "R11 both idle");

    // R10: hardware mode
    sw_mode = 1'b0;
    repeat (4) @(negedge clk);
    xfer({2'b01, 6'h2A}, 8'h00, 8'h3C, 8'h3D, 4, 0, "R10 hardware mode");
    sw_mode = 1'b1;
    repeat (4) @(negedge clk);
    push("R10 values return");

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule